// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block is the central arbiter for a shared bus with six requesters: one internal bus master and five external masters, each with its own request and grant line. Every requester is placed in a high or a low priority group by a control bit, and a pending high-group request always beats every low-group request. Inside each group the grant rotates: the device that most recently started a transaction drops to the back of its group, and the next requester after it in circular order comes first. The internal master sits just before external master 0 in that order.

Arbitration overlaps bus traffic. When the grantee starts its transaction, the next winner is granted at once, and it waits for the bus to be released before it starts. A grant that has not yet been used moves to a better requester as soon as one appears. When requests arrive on an idle bus with no grant outstanding, the arbiter holds off for one clock and then grants. The bus state is given by a busy input and a transaction-start pulse.

The arbiter can be switched off. Its enable comes from a strap input captured on the first clock after reset release, and a control bit can force it off. When it is off, external requester 0's request line carries the internal master's request out to an external arbiter, and its grant line carries the external grant back in. All lines are active-high here. Pad polarity and the tristate buffers are outside the block. Reset is expected to be already synchronised to the clock.

Top module: `tlrr_arbiter`

## Requirements
- R1: Requester index 0 is the internal master and index k+1 is external master k. The rotation order is 0,1,2,3,4,5 and then back to 0. Grants to index 0 appear on `int_gnt_o`, and grants to index k+1 appear on `ext_gnt_o[k]`.
- R2: Bit i of `prio_hi_i` set to 1 puts requester i in the high group. Any pending high-group request wins over all low-group requests.
- R3: Within the winning group, the grant goes to the first requesting index after that group's pointer, in circular order. Indices that are not requesting are skipped. Both pointers reset to 5, so index 0 is searched first.
- R4: When `txn_start_i` is high while a grant is outstanding, the grantee's group pointer takes the grantee's index on that edge. The other pointer is not changed. Without such a start, both pointers hold, including while nothing is requested.
- R5: When a grant is outstanding or `bus_busy_i` is high, the grant outputs show the winner for the request inputs present one clock edge earlier.
- R6: When there is no outstanding grant, `bus_busy_i` is low and requests are present, the first edge grants nothing. The winner is granted on the second edge.
- R7: An outstanding grant that has not been used moves on the next edge to a newly requesting device of higher priority.
- R8: At most one grant is high. With no request pending, all grants are low after the next edge.
- R9: The enable is the `strap_en_i` value captured on the first rising edge after reset release, ANDed with NOT `ctl_disable_i`. Before that capture, the block behaves as disabled.
- R10: While disabled: `ext_gnt_o` is 0; `x0_req_oe_o` is 1 and `x0_req_o` equals `int_req_i`; `x0_gnt_oe_o` is 0 and `int_gnt_o` follows `x0_gnt_i` without delay; `ext_req_i[0]` has no effect. While enabled: `x0_req_oe_o` is 0, `x0_req_o` is 0 and `x0_gnt_oe_o` is 1.
- R11: Disabling clears the internal grant state. After re-enable on an idle bus, the one-cycle hold-off of R6 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Enable strap, captured after reset release |
| ctl_disable_i | input | 1 | Control bit, 1 forces the arbiter off |
| prio_hi_i | input | 6 | Per-requester high-group select |
| int_req_i | input | 1 | Internal master request |
| int_gnt_o | output | 1 | Internal master grant |
| ext_req_i | input | 5 | External master requests |
| ext_gnt_o | output | 5 | External master grants |
| x0_req_o | output | 1 | Outgoing request on requester 0 request pin when disabled |
| x0_req_oe_o | output | 1 | Drive enable for requester 0 request pin |
| x0_gnt_i | input | 1 | Incoming external grant on requester 0 grant pin |
| x0_gnt_oe_o | output | 1 | Drive enable for requester 0 grant pin |
| bus_busy_i | input | 1 | Bus is occupied by a transaction |
| txn_start_i | input | 1 | The grantee starts its transaction this cycle |

## Verification
A wrong rotation pointer stays hidden until the next transaction start that is followed by a contested grant in the same group. At that edge the grant lands on the wrong index. The bench therefore rotates through full groups and through skip patterns, and it checks after a quiet period that the pointer held. A lost or stuck hold-off flag shows on the first edge after requests reach an idle bus: either a grant one cycle too early, or a grant that never comes. A wrong enable shows at once on the requester 0 pin steering outputs. A long sweep over request and priority patterns, with random busy, start and disable inputs, compares every output each cycle against a model written from the requirements.

// File: rtl/tlrr_pkg.sv
package tlrr_pkg;
  typedef enum logic {
    GRP_LO = 1'b0,
    GRP_HI = 1'b1
  } grp_e;
endpackage

// File: rtl/tlrr_pick.sv
module tlrr_pick #(
  parameter int unsigned N = 6,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] cand;

  // Search from the farthest offset down, so the nearest requester after ptr wins.
  always_comb begin
    vld_o = 1'b0;
    idx_o = ptr_i;
    cand  = ptr_i;
    for (int off = N; off >= 1; off--) begin
      cand = W'((int'(ptr_i) + off) % N);
      if (req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = cand;
      end
    end
  end
endmodule

// File: rtl/tlrr_enable.sv
module tlrr_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  input  logic dis_i,
  output logic en_o
);
  logic strap_vld_q, strap_q;
  logic cap_en;

  assign cap_en = ~strap_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_vld_q <= 1'b0;
      strap_q     <= 1'b0;
    end else if (cap_en) begin
      strap_vld_q <= 1'b1;
      strap_q     <= strap_i;
    end
  end

  assign en_o = strap_vld_q & strap_q & ~dis_i;

  // R9: once captured, the strap value never changes until the next reset
  assert_strap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strap_vld_q |=> ($stable(strap_q) && strap_vld_q));
endmodule

// File: rtl/tlrr_grant.sv
module tlrr_grant #(
  parameter int unsigned N = 6,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] prio_i,
  input  logic         busy_i,
  input  logic         txn_start_i,
  output logic [N-1:0] gnt_o
);
  import tlrr_pkg::*;

  localparam logic [W-1:0] PTR_RST = W'(N - 1);

  logic [N-1:0]        gnt_q, gnt_d;
  logic                hold_q, hold_d;
  logic [1:0][W-1:0]   ptr_q, ptr_d;
  logic                ptr_we;
  logic [1:0][N-1:0]   grp_req;
  logic [1:0]          grp_vld;
  logic [1:0][W-1:0]   grp_idx;
  logic [W-1:0]        cur_idx, win_idx;
  logic                any_req, gnt_live;
  grp_e                cur_grp;

  assign any_req  = |req_i;
  assign gnt_live = |gnt_q;
  assign grp_req[GRP_HI] = req_i & prio_i;
  assign grp_req[GRP_LO] = req_i & ~prio_i;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_q[i]) cur_idx = W'(i);
    end
  end

  assign cur_grp = grp_e'(prio_i[cur_idx]);

  // Pointer of the grantee's group moves when its transaction begins.
  always_comb begin
    ptr_we = en_i & txn_start_i & gnt_live;
    ptr_d  = ptr_q;
    if (ptr_we) ptr_d[cur_grp] = cur_idx;
  end

  for (genvar g = 0; g < 2; g++) begin : g_pick
    tlrr_pick #(.N(N)) u_pick (
      .req_i (grp_req[g]),
      .ptr_i (ptr_d[g]),
      .vld_o (grp_vld[g]),
      .idx_o (grp_idx[g])
    );
  end

  assign win_idx = grp_vld[GRP_HI] ? grp_idx[GRP_HI] : grp_idx[GRP_LO];

  always_comb begin
    gnt_d  = '0;
    hold_d = 1'b0;
    if (en_i && any_req) begin
      if (!gnt_live && !busy_i && !hold_q) begin
        hold_d = 1'b1;
      end else begin
        gnt_d = {{(N-1){1'b0}}, 1'b1} << win_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= {PTR_RST, PTR_RST};
    end else if (ptr_we) begin
      ptr_q <= ptr_d;
    end
  end

  assign gnt_o = gnt_q;

  // R8: never more than one grant
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R8: nothing requested means no grant after the edge
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (gnt_q == '0));
  // R5: a grant always answers a request seen on the previous edge
  assert_grant_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |-> $past(any_req));
  // R6: arbitration starting from an idle bus yields no grant on the first edge
  assert_idle_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gnt_live && !busy_i && !hold_q) |=> (gnt_q == '0));
  // R4: the started grantee becomes the reference of its group
  assert_ptr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && txn_start_i && gnt_live) |=> (ptr_q[$past(cur_grp)] == $past(cur_idx)));
  // R11: a disabled arbiter holds no grant state
  assert_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ((gnt_q == '0) && !hold_q));
endmodule

// File: rtl/tlrr_arbiter.sv
module tlrr_arbiter #(
  parameter int unsigned N_EXT = 5,
  localparam int unsigned N_REQ = N_EXT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_en_i,
  input  logic             ctl_disable_i,
  input  logic [N_REQ-1:0] prio_hi_i,
  input  logic             int_req_i,
  output logic             int_gnt_o,
  input  logic [N_EXT-1:0] ext_req_i,
  output logic [N_EXT-1:0] ext_gnt_o,
  output logic             x0_req_o,
  output logic             x0_req_oe_o,
  input  logic             x0_gnt_i,
  output logic             x0_gnt_oe_o,
  input  logic             bus_busy_i,
  input  logic             txn_start_i
);
  logic             en;
  logic [N_REQ-1:0] req_all, gnt_all;

  tlrr_enable u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_en_i),
    .dis_i   (ctl_disable_i),
    .en_o    (en)
  );

  assign req_all = {ext_req_i, int_req_i};

  tlrr_grant #(.N(N_REQ)) u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .req_i       (req_all),
    .prio_i      (prio_hi_i),
    .busy_i      (bus_busy_i),
    .txn_start_i (txn_start_i),
    .gnt_o       (gnt_all)
  );

  // Pin steering: disabled turns requester 0 pins around toward an external arbiter.
  assign int_gnt_o   = en ? gnt_all[0] : x0_gnt_i;
  assign ext_gnt_o   = en ? gnt_all[N_REQ-1:1] : '0;
  assign x0_req_o    = en ? 1'b0 : int_req_i;
  assign x0_req_oe_o = ~en;
  assign x0_gnt_oe_o = en;

  // R10: pin direction for requester 0 is always exclusive
  assert_pin_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (x0_req_oe_o != x0_gnt_oe_o));
  // R10: while off, no external grant is driven even one cycle after disabling
  assert_off_no_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    x0_req_oe_o |-> (ext_gnt_o == '0));
endmodule

// File: tb/tb_tlrr_arbiter.sv
module tb_tlrr_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_en_i, ctl_disable_i;
  logic [5:0] prio_hi_i;
  logic       int_req_i, int_gnt_o;
  logic [4:0] ext_req_i, ext_gnt_o;
  logic       x0_req_o, x0_req_oe_o, x0_gnt_i, x0_gnt_oe_o;
  logic       bus_busy_i, txn_start_i;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int   m_gnt;
  bit   m_hold, m_vld, m_strap;
  int   m_ptr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlrr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .strap_en_i(strap_en_i), .ctl_disable_i(ctl_disable_i),
    .prio_hi_i(prio_hi_i), .int_req_i(int_req_i), .int_gnt_o(int_gnt_o),
    .ext_req_i(ext_req_i), .ext_gnt_o(ext_gnt_o), .x0_req_o(x0_req_o),
    .x0_req_oe_o(x0_req_oe_o), .x0_gnt_i(x0_gnt_i), .x0_gnt_oe_o(x0_gnt_oe_o),
    .bus_busy_i(bus_busy_i), .txn_start_i(txn_start_i)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ctl_disable_i = 1'b0; prio_hi_i = '0; int_req_i = 1'b0; ext_req_i = '0;
    x0_gnt_i = 1'b0; bus_busy_i = 1'b0; txn_start_i = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_en_i = strap;
    idle_inputs();
    m_gnt = -1; m_hold = 0; m_vld = 0; m_strap = 0;
    m_ptr[0] = 5; m_ptr[1] = 5;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  function automatic int pick(input logic [5:0] req, input logic [5:0] prio);
    logic [5:0] set;
    int p;
    set = ((req & prio) != 0) ? (req & prio) : (req & ~prio);
    p   = ((req & prio) != 0) ? m_ptr[1] : m_ptr[0];
    for (int off = 1; off <= 6; off++) begin
      if (set[(p + off) % 6]) return (p + off) % 6;
    end
    return -1;
  endfunction

  // one clock edge of the requirement model, using the inputs held over the edge
  task automatic model_step();
    logic [5:0] req;
    bit en_now;
    int g;
    req = {ext_req_i, int_req_i};
    en_now = m_vld && m_strap && !ctl_disable_i;
    g = m_gnt;
    if (en_now && txn_start_i && g >= 0) m_ptr[prio_hi_i[g]] = g;
    if (!en_now || req == 0) begin
      m_gnt = -1; m_hold = 0;
    end else if (g < 0 && !bus_busy_i && !m_hold) begin
      m_gnt = -1; m_hold = 1;
    end else begin
      m_gnt = pick(req, prio_hi_i); m_hold = 0;
    end
    if (!m_vld) begin
      m_vld = 1; m_strap = strap_en_i;
    end
  endtask

  task automatic model_compare();
    bit en2;
    logic [4:0] ext_exp;
    logic int_exp;
    en2 = m_vld && m_strap && !ctl_disable_i;
    int_exp = en2 ? (m_gnt == 0) : x0_gnt_i;
    ext_exp = (en2 && m_gnt > 0) ? (5'b1 << (m_gnt - 1)) : 5'b0;
    chk("R1 R2 R3 R5 R6 R7 sweep grants", {ext_gnt_o, int_gnt_o}, {ext_exp, int_exp});
    chk("R10 sweep pins", {x0_req_o, x0_req_oe_o, x0_gnt_oe_o},
        {(en2 ? 1'b0 : int_req_i), !en2, en2});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    strap_en_i = 1'b1;
    idle_inputs();
    do_reset(1'b1);

    // ---- before capture: disabled pass-through (R9, R10)
    rst_n = 1'b0;
    x0_gnt_i = 1'b1; #1;
    chk("R9 reset oe", x0_req_oe_o, 1'b1);
    chk("R10 reset ext grants", ext_gnt_o, 5'b0);
    chk("R10 reset int grant follows pin", int_gnt_o, 1'b1);
    x0_gnt_i = 1'b0;
    rst_n = 1'b1;
    cyc();
    chk("R9 enabled after capture", {x0_req_oe_o, x0_gnt_oe_o}, 2'b01);
    cyc();
    chk("R8 no request no grant", {ext_gnt_o, int_gnt_o}, 6'b0);

    // ---- R6 idle hold-off
    ext_req_i = 5'b00100;
    cyc();
    chk("R6 first edge withheld", ext_gnt_o, 5'b0);
    cyc();
    chk("R6 second edge granted", ext_gnt_o, 5'b00100);

    // ---- R7 / R2 pre-emption by a high-group request
    prio_hi_i = 6'b100000; ext_req_i = 5'b10100;
    cyc();
    chk("R7 R2 pre-empt to high", ext_gnt_o, 5'b10000);

    // ---- R4 start moves high pointer, low group serves next
    bus_busy_i = 1'b1; txn_start_i = 1'b1; ext_req_i = 5'b00100;
    cyc();
    chk("R4 R5 next winner after start", ext_gnt_o, 5'b00100);
    txn_start_i = 1'b0;

    // ---- R3 full rotation, internal before external 0
    prio_hi_i = '0; int_req_i = 1'b1; ext_req_i = 5'b11111;
    cyc();
    chk("R3 R1 wrap to internal", {ext_gnt_o, int_gnt_o}, 6'b000001);
    txn_start_i = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      cyc();
      chk("R3 R1 rotation", {ext_gnt_o, int_gnt_o}, 6'b1 << (k % 6));
    end

    // ---- R3 skipping of idle requesters
    int_req_i = 1'b0; ext_req_i = 5'b01010;
    cyc();
    chk("R3 skip a", ext_gnt_o, 5'b00010);
    cyc();
    chk("R3 skip b", ext_gnt_o, 5'b01000);
    cyc();
    chk("R3 skip wrap", ext_gnt_o, 5'b00010);

    // ---- R8 release, R4 pointer holds while idle
    txn_start_i = 1'b0; ext_req_i = 5'b0;
    cyc();
    chk("R8 release", {ext_gnt_o, int_gnt_o}, 6'b0);
    cyc();
    ext_req_i = 5'b01010;
    cyc();
    chk("R4 pointer held", ext_gnt_o, 5'b00010);

    // ---- R10 disabled pass-through
    ctl_disable_i = 1'b1; int_req_i = 1'b1; ext_req_i = 5'b00001; x0_gnt_i = 1'b1;
    #1;
    chk("R10 req out", {x0_req_o, x0_req_oe_o, x0_gnt_oe_o}, 3'b110);
    chk("R10 grant in", int_gnt_o, 1'b1);
    chk("R10 ext grants masked", ext_gnt_o, 5'b0);
    cyc();
    chk("R10 ext req0 ignored", ext_gnt_o, 5'b0);
    x0_gnt_i = 1'b0; #1;
    chk("R10 grant in low", int_gnt_o, 1'b0);

    // ---- R11 re-enable from idle
    ctl_disable_i = 1'b0; bus_busy_i = 1'b0; ext_req_i = 5'b0;
    #1;
    chk("R11 state cleared", {ext_gnt_o, int_gnt_o}, 6'b0);
    cyc();
    chk("R11 hold-off again", int_gnt_o, 1'b0);
    cyc();
    chk("R11 granted", int_gnt_o, 1'b1);

    // ---- R9 strap low keeps the arbiter off
    do_reset(1'b0);
    int_req_i = 1'b1; ext_req_i = 5'b11111; bus_busy_i = 1'b1;
    cyc(); cyc(); cyc();
    chk("R9 strap off", {x0_req_oe_o, x0_gnt_oe_o, ext_gnt_o}, 7'b1000000);
    chk("R9 strap off pass", {x0_req_o, int_gnt_o}, 2'b10);

    // ---- sweep against the requirement model
    do_reset(1'b1);
    lfsr = 16'hACE1;
    for (int i = 0; i < 4096; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      {ext_req_i, int_req_i} = 6'(i) ^ 6'(lfsr[5:0] & {6{lfsr[15]}});
      prio_hi_i     = 6'(i >> 6) ^ lfsr[11:6];
      bus_busy_i    = lfsr[1];
      txn_start_i   = lfsr[2] & lfsr[7];
      ctl_disable_i = (lfsr[13:10] == 4'd0);
      x0_gnt_i      = lfsr[9];
      @(posedge clk);
      model_step();
      @(negedge clk);
      model_compare();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule